// File: doc/BRIEF.md
# Priority Interrupt Controller

An eight-line interrupt controller reached through one byte-wide register port. Software programs it through a command register, a data register and a trigger-mode register. Each incoming line is latched into a request register. Requests that are not masked compete under a rotatable priority order. The winner raises `int_out` unless a line of equal or higher priority is already being serviced. The CPU side answers with a one-cycle `ack` strobe. The controller then moves the winning line into the in-service register and places an 8-bit vector on `vector`.

After reset the block is uninitialised. A command write with bit 4 set starts the setup sequence. Three data writes must follow: the vector base, a cascade word and a mode word. The controller works normally only after the third of them. End-of-interrupt commands clear in-service bits. Rotation commands move the priority order. Automatic end-of-interrupt, optionally with rotation, removes the need for software end-of-interrupt. Special mask mode lets lower-priority lines through while a handler runs. A cascade request input is merged into line 2, so that a second controller can be chained behind this one.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A command write (reg_sel 0) with bit 4 set clears the mask, the in-service bits, the priority base, special mask mode and the automatic end-of-interrupt settings. It also drops the latched edge requests and expects three data writes (reg_sel 1): first the vector base in bits 7:3, then a cascade word, then a mode word. `int_out` stays low until the mode word has been written.
- R2: An `ack` while a request is pending sets that line's in-service bit (unless automatic end-of-interrupt is on) and clears its edge-latched request. On the next cycle `vector` holds {base[7:3], line[2:0]}.
- R3: The pending line is the first set bit of the unmasked requests, taking lines in the order base, base+1 … base+7 (mod 8). An in-service line blocks itself and every line after it in that order. A command write with bits 4:3 = 00 is an operation word coded in bits 7:5. Code 1 clears the highest-priority in-service bit. Code 3 clears the in-service bit named in bits 2:0. Code 2 does nothing.
- R4: Operation code 5 clears the highest-priority in-service bit and makes that line the lowest priority. Code 7 clears the line named in bits 2:0 and makes it the lowest priority. Code 6 only makes the named line the lowest priority. A line made lowest sets the base to that line + 1.
- R5: Mode-word bit 1 enables automatic end-of-interrupt: `ack` leaves the in-service register unchanged. Operation code 4 enables rotation on such an acknowledge, which makes the acknowledged line the lowest priority. Code 0 disables that rotation.
- R6: A command write with bit 7 = 0, bit 4 = 0 and bit 3 = 1 is a control word. When its bit 1 is set, its bit 0 chooses what `rdata` shows for reg_sel 0: in-service (1) or request (0). `rdata` shows the mask for reg_sel 1.
- R7: In that control word, bit 6 = 1 loads special mask mode from bit 5. While special mask mode is on and the mask is nonzero, in-service bits do not block any request.
- R8: A line whose mask bit is set never causes `int_out`. A request that was latched while masked is delivered once the mask bit is cleared.
- R9: The trigger-mode register (reg_sel 2) can be written and read. A bit of 1 makes the request follow the line level. A bit of 0 latches the request on a rising edge and holds it after the line falls.
- R10: The `casc_in` input is ORed into line 2 before request detection.
- R11: An `ack` with nothing pending leaves the in-service register unchanged. On the next cycle `vector` holds {base[7:3], 3'b111}.
- R12: After reset `int_out` is low, the mask reads 0 and the block waits for a setup sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt lines |
| casc_in | input | 1 | Request from a chained controller, merged into line 2 |
| reg_sel | input | 2 | 0 command, 1 data/mask, 2 trigger mode |
| wr_en | input | 1 | Write strobe for the selected register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Readback of the selected register (combinational) |
| ack | input | 1 | Acknowledge strobe |
| vector | output | 8 | Vector captured at the last acknowledge |
| int_out | output | 1 | Interrupt request to the CPU |

## Verification
The bench aims at the places where an ordering mistake stays invisible in simple traffic.

- **Request raised during setup.** A request is raised while the setup sequence is only half done. A controller that leaves setup too early would raise `int_out` before the mode word arrives.
- **Rotation forms.** Each rotation form is followed by two requests that fixed priority would order the other way. A wrong base update shows up as the wrong vector.
- **Special mask mode.** A lower line is blocked by an in-service line, then released by special mask mode. A resolver that ignores the mode never raises the interrupt.
- **Spurious and level cases.** A spurious acknowledge must return level 7 and leave in-service untouched. A level line must drop its request when the line falls, while an edge line keeps it.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  input  logic       casc_in,
  input  logic [1:0] reg_sel,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ack,
  output logic [7:0] vector,
  output logic       int_out
);
  typedef enum logic [2:0] {S_UNINIT, S_W2, S_W3, S_W4, S_RUN} setup_t;

  setup_t     ist;
  logic [7:0] irr, isr, imr, elcr, line_q;
  logic [4:0] vbase;
  logic [2:0] base;
  logic       aeoi_mode, rot_aeoi, smm, rd_isr;

  function automatic logic [3:0] pick(input logic [7:0] v, input logic [2:0] b);
    logic [7:0] r;
    r = (v >> b) | (v << (4'd8 - {1'b0, b}));
    pick = 4'd0;
    for (int i = 7; i >= 0; i--)
      if (r[i]) pick = {1'b1, 3'(i) + b};
  endfunction

  wire [7:0] lines   = irq_in | {5'b0, casc_in, 2'b0};
  wire [7:0] rise    = lines & ~line_q;
  wire [7:0] blk     = (smm && imr != 8'h00) ? 8'h00 : isr;
  wire [3:0] req_pk  = pick((irr & ~imr) | blk, base);
  wire       pend    = req_pk[3] && !blk[req_pk[2:0]];
  wire [3:0] isr_pk  = pick(isr, base);
  wire       running = (ist == S_RUN);
  wire       cmd_wr  = wr_en && reg_sel == 2'd0;
  wire       data_wr = wr_en && reg_sel == 2'd1;
  wire       el_wr   = wr_en && reg_sel == 2'd2;
  wire       icw1    = cmd_wr && wdata[4];
  wire       ack_go  = ack && !wr_en && running && pend;
  wire [2:0] lvl     = wdata[2:0];
  wire [7:0] lvl_bit = 8'h01 << lvl;
  wire [7:0] win_bit = 8'h01 << req_pk[2:0];
  wire [7:0] top_isr = isr_pk[3] ? (8'h01 << isr_pk[2:0]) : 8'h00;

  assign int_out = running && pend;

  always_comb begin
    case (reg_sel)
      2'd0:    rdata = rd_isr ? isr : irr;
      2'd1:    rdata = imr;
      2'd2:    rdata = elcr;
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr    <= 8'h00;
      line_q <= 8'h00;
    end else begin
      line_q <= lines;
      if (icw1)
        irr <= lines & elcr;
      else
        irr <= (elcr & lines) | (~elcr & (rise | (irr & ~(ack_go ? win_bit : 8'h00))));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ist       <= S_UNINIT;
      isr       <= 8'h00;
      imr       <= 8'h00;
      elcr      <= 8'h00;
      vbase     <= 5'd0;
      base      <= 3'd0;
      aeoi_mode <= 1'b0;
      rot_aeoi  <= 1'b0;
      smm       <= 1'b0;
      rd_isr    <= 1'b0;
      vector    <= 8'h00;
    end else if (icw1) begin
      ist       <= S_W2;
      isr       <= 8'h00;
      imr       <= 8'h00;
      base      <= 3'd0;
      aeoi_mode <= 1'b0;
      rot_aeoi  <= 1'b0;
      smm       <= 1'b0;
      rd_isr    <= 1'b0;
    end else if (cmd_wr && running && wdata[4:3] == 2'b00) begin
      case (wdata[7:5])
        3'd0: rot_aeoi <= 1'b0;
        3'd1: isr <= isr & ~top_isr;
        3'd3: isr <= isr & ~lvl_bit;
        3'd4: rot_aeoi <= 1'b1;
        3'd5: if (isr_pk[3]) begin
                isr  <= isr & ~top_isr;
                base <= isr_pk[2:0] + 3'd1;
              end
        3'd6: base <= lvl + 3'd1;
        3'd7: begin
                isr  <= isr & ~lvl_bit;
                base <= lvl + 3'd1;
              end
        default: ;
      endcase
    end else if (cmd_wr && running && !wdata[7] && wdata[4:3] == 2'b01) begin
      if (wdata[1]) rd_isr <= wdata[0];
      if (wdata[6]) smm <= wdata[5];
    end else if (data_wr) begin
      case (ist)
        S_W2: begin vbase <= wdata[7:3]; ist <= S_W3; end
        S_W3: ist <= S_W4;
        S_W4: begin aeoi_mode <= wdata[1]; ist <= S_RUN; end
        default: imr <= wdata;
      endcase
    end else if (el_wr) begin
      elcr <= wdata;
    end else if (ack && !wr_en) begin
      if (ack_go) begin
        vector <= {vbase, req_pk[2:0]};
        if (!aeoi_mode)    isr  <= isr | win_bit;
        else if (rot_aeoi) base <= req_pk[2:0] + 3'd1;
      end else begin
        vector <= {vbase, 3'd7};
      end
    end
  end
endmodule

module prio_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] reg_sel,
  input logic [7:0] wdata,
  input logic       ack,
  input logic       int_out,
  input logic [7:0] vector,
  input logic [7:0] isr,
  input logic [7:0] irr,
  input logic [7:0] imr,
  input logic       aeoi_mode
);
  a_r1_quiet_after_icw1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_sel == 2'd0 && wdata[4]) |=> !int_out);
  a_r2_ack_fills_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_en && int_out && !aeoi_mode) |=> isr != 8'h00);
  a_r2_vector_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(vector));
  a_r5_aeoi_no_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_en && aeoi_mode && isr == 8'h00) |=> isr == 8'h00);
  a_r8_int_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr & ~imr) != 8'h00);
  a_r11_spurious_low7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !wr_en && !int_out) |=> vector[2:0] == 3'd7);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (.*);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = 8'h00;
  logic       casc_in = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       ack = 1'b0;
  logic [7:0] vector;
  logic       int_out;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_lines(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    reg_sel = s; #1; v = rdata;
  endtask

  task automatic do_ack(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  // monitor: pops the expected vector one cycle after each acknowledge
  always @(posedge clk) begin
    if (ack) begin
      @(negedge clk);
      if (exp_q.size() == 0) chk(vector, 8'hxx, "R2 unexpected ack");
      else chk(vector, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({7'd0, int_out}, 8'h00, "R12 int after reset");
    rd(2'd1, v); chk(v, 8'h00, "R12 mask after reset");

    wr(0, 8'h11); wr(1, 8'h20);
    set_lines(8'h08);
    chk({7'd0, int_out}, 8'h00, "R1 int during setup");
    wr(1, 8'h04); wr(1, 8'h01);
    chk({7'd0, int_out}, 8'h01, "R1 int after setup");
    do_ack(8'h23, "R2 vector line3");
    chk({7'd0, int_out}, 8'h00, "R2 int after ack");
    wr(0, 8'h0B); rd(2'd0, v); chk(v, 8'h08, "R6 isr readback");
    wr(0, 8'h0A); rd(2'd0, v); chk(v, 8'h00, "R2 edge request cleared");

    set_lines(8'h2A);
    chk({7'd0, int_out}, 8'h01, "R3 higher line preempts");
    do_ack(8'h21, "R3 line1 wins");
    wr(0, 8'h20); wr(0, 8'h0B); rd(2'd0, v); chk(v, 8'h08, "R3 nonspecific eoi");
    chk({7'd0, int_out}, 8'h00, "R3 lower line blocked");
    wr(0, 8'h63);
    chk({7'd0, int_out}, 8'h01, "R3 specific eoi unblocks");
    do_ack(8'h25, "R3 line5");
    wr(0, 8'h20); rd(2'd0, v); chk(v, 8'h00, "R3 isr empty");

    set_lines(8'h00); set_lines(8'h11);
    do_ack(8'h20, "R4 line0 first");
    wr(0, 8'hE0);
    set_lines(8'h10); set_lines(8'h11);
    do_ack(8'h24, "R4 rotate specific");
    wr(0, 8'h64);
    do_ack(8'h20, "R4 line0 later");
    wr(0, 8'h60);

    set_lines(8'h00); wr(0, 8'hC4);
    set_lines(8'h44);
    do_ack(8'h26, "R4 set priority");
    wr(0, 8'h66);
    do_ack(8'h22, "R4 set priority second");
    wr(0, 8'h62);

    set_lines(8'h00); set_lines(8'h82);
    do_ack(8'h27, "R4 line7 under base5");
    wr(0, 8'hA0);
    set_lines(8'hC2);
    do_ack(8'h21, "R4 rotate nonspecific");
    wr(0, 8'h61);
    do_ack(8'h26, "R4 line6 after");
    wr(0, 8'h66);

    set_lines(8'h00); set_lines(8'h08);
    do_ack(8'h23, "R7 setup line3");
    set_lines(8'h28);
    chk({7'd0, int_out}, 8'h00, "R7 blocked before smm");
    wr(1, 8'h01); wr(0, 8'h68);
    chk({7'd0, int_out}, 8'h01, "R7 smm releases");
    do_ack(8'h25, "R7 line5 in smm");
    wr(0, 8'h48); wr(0, 8'h65); wr(0, 8'h63); wr(1, 8'h00);

    set_lines(8'h00); wr(1, 8'h01); set_lines(8'h01);
    chk({7'd0, int_out}, 8'h00, "R8 masked line");
    rd(2'd1, v); chk(v, 8'h01, "R6 mask readback");
    wr(1, 8'h00);
    chk({7'd0, int_out}, 8'h01, "R8 unmasked later");
    do_ack(8'h20, "R8 line0");
    wr(0, 8'h60);

    set_lines(8'h00);
    do_ack(8'h27, "R11 spurious vector");
    rd(2'd0, v); chk(v, 8'h00, "R11 isr untouched");

    wr(2, 8'h02); rd(2'd2, v); chk(v, 8'h02, "R9 mode readback");
    set_lines(8'h02);
    chk({7'd0, int_out}, 8'h01, "R9 level high");
    set_lines(8'h00);
    chk({7'd0, int_out}, 8'h00, "R9 level follows");
    set_lines(8'h08); set_lines(8'h00);
    chk({7'd0, int_out}, 8'h01, "R9 edge held");
    do_ack(8'h23, "R9 edge line3");
    wr(0, 8'h63); wr(2, 8'h00);

    @(negedge clk); casc_in = 1'b1; @(negedge clk);
    chk({7'd0, int_out}, 8'h01, "R10 cascade request");
    do_ack(8'h22, "R10 cascade vector");
    casc_in = 1'b0; wr(0, 8'h62);

    wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h04); wr(1, 8'h03);
    set_lines(8'h04);
    do_ack(8'h42, "R5 aeoi vector");
    wr(0, 8'h0B); rd(2'd0, v); chk(v, 8'h00, "R5 isr not kept");
    wr(0, 8'h80);
    set_lines(8'h2C);
    do_ack(8'h43, "R5 line3 first");
    set_lines(8'h24); set_lines(8'h2C);
    do_ack(8'h45, "R5 rotated in aeoi");
    do_ack(8'h43, "R5 line3 last");

    repeat (2) @(negedge clk);
    chk(8'(exp_q.size()), 8'h00, "R2 all acks observed");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule